// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is one 32-pin general-purpose I/O port seen by software as eight word-wide registers on a simple single-cycle bus. Software sets each pin's driven value and its direction. It reads back the synchronized level of every pin, including pins that are driving. Each pin has its own event detector. Software sets it to sense a rising edge, a falling edge, a high level or a low level, and gates it with a per-pin source select. Detected events latch into a sticky status register. The status, masked by a per-pin interrupt enable, is reduced to one interrupt line for the whole port.

Every writable register has three views at consecutive word offsets. One replaces the register, one ORs the write data into it, and one clears the bits where the write data holds ones. This lets several software agents change single pins without a read-modify-write race. The status register can only be cleared, and only through its clear view.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `pin_out` and `pin_oe` are zero (all pins inputs) and `irq_out` is low.
- R2: Bits [6:4] of the byte address select the register: data-out 0x00, output-enable 0x10, data-in 0x20, source-select 0x30, interrupt-enable 0x40, level-select 0x50, polarity 0x60, status 0x70. Bits [3:2] select the view: offset 0x0 replaces, 0x4 ORs in the write data, 0x8 clears the bits set in the write data, and writes at 0xC are ignored. An access with bits [1:0] or any bit above 6 nonzero neither writes nor reads (it reads 0).
- R3: A read at any of the four views of a register returns the register's current value.
- R4: `pin_out` carries the data-out register and `pin_oe` the output-enable register. An output-enable bit of 1 makes that pin an output.
- R5: The data-in register holds each pin's level after a two-flop synchronizer. It reads the same whether the pin is an input or an output, and writes to it are ignored.
- R6: Per pin, {polarity, level-select} selects the detection mode: 0 falling edge, 1 low level, 2 rising edge, 3 high level. An edge is a difference between two consecutive synchronized samples; the opposite edge sets nothing.
- R7: A status bit can only become set while the pin's source-select bit is 1.
- R8: Status bits are sticky. Only a write of ones to the status clear view (0x78) clears them; writes to 0x70 and 0x74 leave status unchanged.
- R9: In a level mode the status bit sets again on every cycle the level stays active. A detection in the same cycle as a clear wins, so the bit reads as set right after the clear.
- R10: `irq_out` is high exactly when some bit is set in both status and interrupt-enable (default combinational output).
- R11: A pin change present at clock edge e shows as a set status bit after edge e+2, and not after edge e+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, same cycle |
| pin_in | input | PINS (32) | Asynchronous pin levels |
| pin_out | output | PINS (32) | Driven pin values |
| pin_oe | output | PINS (32) | Per-pin output enable |
| irq_out | output | 1 | Port interrupt |

## Verification
The assertions assume `pin_in` is held at zero during reset and for the first cycles after it. Without that, the data-in check would compare against samples taken before the synchronizer was released. The stimulus meets this by keeping all pins low until well after reset. It changes pins only at falling clock edges, and it waits at least four cycles before reading status, so every change has crossed both synchronizer flops. The bench also assumes bus accesses are word-aligned and within the port, except for the deliberate out-of-range writes that must be ignored.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [1:0] {
      VIEW_PUT  = 2'd0,
      VIEW_OR   = 2'd1,
      VIEW_AND  = 2'd2,
      VIEW_NONE = 2'd3
   } view_e;

   typedef enum logic [2:0] {
      IDX_DOUT = 3'd0,
      IDX_OE   = 3'd1,
      IDX_DIN  = 3'd2,
      IDX_SRC  = 3'd3,
      IDX_IEN  = 3'd4,
      IDX_LVL  = 3'd5,
      IDX_POL  = 3'd6,
      IDX_STAT = 3'd7
   } reg_idx_e;

   localparam int REG_COUNT = 8;
   localparam int VIEW_LSB  = 2;
   localparam int IDX_LSB   = 4;
   localparam int MAP_BITS  = 7;
   localparam int MAX_PINS  = 32;

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
   import gpio_irq_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  view_e        view,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   logic [W-1:0] nxt;

   always_comb begin
      case (view)
         VIEW_PUT: nxt = wdata;
         VIEW_OR:  nxt = q | wdata;
         VIEW_AND: nxt = q & ~wdata;
         default:  nxt = q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= nxt;
   end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] samp,
   input  logic [W-1:0] src_en,
   input  logic [W-1:0] lvl_sel,
   input  logic [W-1:0] pol_sel,
   output logic [W-1:0] hit
);

   logic [W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= samp;
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      logic raw;
      always_comb begin
         case ({pol_sel[i], lvl_sel[i]})
            2'd0:    raw = prev[i] & ~samp[i];
            2'd1:    raw = ~samp[i];
            2'd2:    raw = samp[i] & ~prev[i];
            default: raw = samp[i];
         endcase
      end
      assign hit[i] = raw & src_en[i];
   end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hit,
   input  logic         clr_en,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] stat
);

   logic [W-1:0] kill;

   assign kill = clr_en ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~kill) | hit;
   end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int PINS        = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic              irq_out
);

   initial begin
      assert (PINS >= 1 && PINS <= MAX_PINS) else $error("PINS out of range");
      assert (DATA_W >= PINS) else $error("DATA_W narrower than PINS");
      assert (ADDR_W >= MAP_BITS) else $error("ADDR_W too small for map");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES below 2");
   end

   logic              bus_hit;
   logic [2:0]        reg_idx;
   view_e             view;
   logic [PINS-1:0]   wr_bits;
   logic [PINS-1:0]   cfg_q [REG_COUNT];
   logic [PINS-1:0]   din_q;
   logic [PINS-1:0]   stat_q;
   logic [PINS-1:0]   src_q;
   logic [PINS-1:0]   ien_q;
   logic [PINS-1:0]   hit;
   logic [PINS-1:0]   rd_vec;
   logic              stat_clr;
   logic              irq_now;

   assign bus_hit = bus_sel && (bus_addr[1:0] == 2'b00)
                    && ((bus_addr >> MAP_BITS) == '0);
   assign reg_idx = bus_addr[IDX_LSB+2:IDX_LSB];
   assign view    = view_e'(bus_addr[VIEW_LSB+1:VIEW_LSB]);
   assign wr_bits = bus_wdata[PINS-1:0];

   for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
      if (i != int'(IDX_DIN) && i != int'(IDX_STAT)) begin : g_rw
         logic wr_en;
         assign wr_en = bus_hit && bus_we && (reg_idx == 3'(i))
                        && (view != VIEW_NONE);
         gpio_alias_reg #(.W(PINS)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .view  (view),
            .wdata (wr_bits),
            .q     (cfg_q[i])
         );
      end else begin : g_ro
         assign cfg_q[i] = '0;
      end
   end

   assign src_q = cfg_q[IDX_SRC];
   assign ien_q = cfg_q[IDX_IEN];

   gpio_pin_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (din_q)
   );

   gpio_irq_detect #(.W(PINS)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .samp    (din_q),
      .src_en  (src_q),
      .lvl_sel (cfg_q[IDX_LVL]),
      .pol_sel (cfg_q[IDX_POL]),
      .hit     (hit)
   );

   assign stat_clr = bus_hit && bus_we && (reg_idx == IDX_STAT)
                     && (view == VIEW_AND);

   gpio_irq_status #(.W(PINS)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .clr_en   (stat_clr),
      .clr_mask (wr_bits),
      .stat     (stat_q)
   );

   always_comb begin
      case (reg_idx)
         IDX_DIN:  rd_vec = din_q;
         IDX_STAT: rd_vec = stat_q;
         default:  rd_vec = cfg_q[reg_idx];
      endcase
      bus_rdata = '0;
      if (bus_hit) bus_rdata[PINS-1:0] = rd_vec;
   end

   assign pin_out = cfg_q[IDX_DOUT];
   assign pin_oe  = cfg_q[IDX_OE];
   assign irq_now = |(stat_q & ien_q);

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_out <= 1'b0;
         else        irq_out <= irq_now;
      end
   end else begin : g_irq_comb
      assign irq_out = irq_now;
   end

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
   parameter int PINS        = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [PINS-1:0]   pin_in,
   input logic [PINS-1:0]   pin_out,
   input logic [PINS-1:0]   pin_oe,
   input logic              irq_out,
   input logic [PINS-1:0]   stat,
   input logic [PINS-1:0]   src,
   input logic [PINS-1:0]   ien
);

   logic            in_map;
   logic [PINS-1:0] clr_mask;
   logic            oe_wr;
   logic            dout_wr;
   logic            din_rd;
   logic [1:0]      age;

   assign in_map   = bus_sel && (bus_addr[1:0] == 2'b00) && ((bus_addr >> 7) == '0);
   assign clr_mask = (in_map && bus_we && bus_addr[6:2] == 5'b11110)
                     ? bus_wdata[PINS-1:0] : '0;
   assign oe_wr    = in_map && bus_we && bus_addr[6:4] == 3'd1 && bus_addr[3:2] != 2'd3;
   assign dout_wr  = in_map && bus_we && bus_addr[6:4] == 3'd0 && bus_addr[3:2] != 2'd3;
   assign din_rd   = in_map && !bus_we && bus_addr[6:4] == 3'd2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age <= '0;
      else if (age != 3) age <= age + 2'd1;
   end

   // R8: a set status bit survives unless the clear view hit it
   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(stat) & ~$past(clr_mask)) & ~stat) == '0));

   // R7: newly set status bits had their source select on
   assert_src_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat & ~$past(stat) & ~$past(src)) == '0));

   // R4: pin direction and value move only on a write to their registers
   assert_oe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_wr |=> $stable(pin_oe));
   assert_dout_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_wr |=> $stable(pin_out));

   // R10: no interrupt without pending status; interrupt while status and enable overlap
   assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat) == '0 && stat == '0) |-> !irq_out);
   assert_irq_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(stat & ien) != '0) && ((stat & ien) != '0)) |-> irq_out);

   // R5: data-in reads the pins two samples back
   if (SYNC_STAGES == 2) begin : g_din
      assert_din_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (din_rd && age == 2'd3) |-> (bus_rdata[PINS-1:0] == $past(pin_in, 2)));
   end

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
   .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_out   (irq_out),
   .stat      (stat_q),
   .src       (src_q),
   .ien       (ien_q)
);

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;

   localparam logic [7:0] A_DOUT = 8'h00, A_OE = 8'h10, A_DIN = 8'h20, A_SRC = 8'h30,
                          A_IEN = 8'h40, A_LVL = 8'h50, A_POL = 8'h60, A_STAT = 8'h70;
   localparam logic [31:0] ALL = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] pins = '0;
   logic [31:0] pout, poe;
   logic        irq;
   int          checks = 0, fails = 0;

   always #10 clk = ~clk;

   gpio_irq_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pins), .pin_out(pout),
      .pin_oe(poe), .irq_out(irq)
   );

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      sel = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; we = 1'b0; addr = a;
      #1 d = rdata;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] d, e, a_v, b_v, c_v;
      logic [7:0]  base;
      int          p;
      logic        lv, pl;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (4) @(posedge clk);

      // R1 reset state
      for (int i = 0; i < 8; i++) begin
         rd(8'(i * 16), d);
         chk("R1 register reset", d, 32'h0);
      end
      chk("R1 pin_oe reset", poe, 32'h0);
      chk("R1 pin_out reset", pout, 32'h0);
      chk("R1 irq reset", {31'h0, irq}, 32'h0);

      // R2 R3 view arithmetic on every writable register
      for (int i = 0; i < 6; i++) begin
         base = (i == 0) ? A_DOUT : (i == 1) ? A_OE : (i == 2) ? A_SRC :
                (i == 3) ? A_IEN : (i == 4) ? A_LVL : A_POL;
         a_v = 32'hA5A5_0F0F ^ (32'h1111_1111 * i);
         b_v = 32'h0000_F0F0 << i;
         c_v = 32'h0F00_00FF << i;
         wr(base, a_v);
         rd(base, d);
         chk("R2 replace view", d, a_v);
         wr(base + 8'h4, b_v);
         rd(base, d);
         chk("R2 or view", d, a_v | b_v);
         wr(base + 8'h8, c_v);
         e = (a_v | b_v) & ~c_v;
         for (int v = 0; v < 4; v++) begin
            rd(base + 8'(v * 4), d);
            chk("R3 read through every view", d, e);
         end
         wr(base + 8'hC, ~e);
         rd(base, d);
         chk("R2 write at offset 0xC ignored", d, e);
      end

      // R4 pins follow data-out and output-enable
      wr(A_DOUT, 32'h1234_5678);
      wr(A_OE, 32'hFFFF_0000);
      @(negedge clk);
      chk("R4 pin_out", pout, 32'h1234_5678);
      chk("R4 pin_oe", poe, 32'hFFFF_0000);

      // R2 misaligned or out-of-map accesses
      wr(8'h80, 32'hDEAD_BEEF);
      wr(8'h01, 32'hDEAD_BEEF);
      rd(A_DOUT, d);
      chk("R2 out-of-map write ignored", d, 32'h1234_5678);
      rd(8'h80, d);
      chk("R2 out-of-map read is zero", d, 32'h0);

      // clean configuration
      wr(A_SRC + 8'h8, ALL); wr(A_LVL + 8'h8, ALL); wr(A_POL + 8'h8, ALL);
      wr(A_IEN + 8'h8, ALL); wr(A_DOUT, 32'h0);
      repeat (4) @(posedge clk);
      wr(A_STAT + 8'h8, ALL);
      rd(A_STAT, d);
      chk("R8 status cleared", d, 32'h0);

      // R5 data-in with pins as outputs and inputs
      pins = 32'hC3A5_5A3C;
      repeat (4) @(posedge clk);
      rd(A_DIN, d);
      chk("R5 data-in while outputs", d, 32'hC3A5_5A3C);
      wr(A_OE, 32'h0);
      wr(A_DIN, ~pins);
      rd(A_DIN, d);
      chk("R5 data-in while inputs, write ignored", d, 32'hC3A5_5A3C);
      pins = '0;
      repeat (4) @(posedge clk);

      // R6 R8 R9 sweep of all modes over several pins
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 3; k++) begin
            p  = (k == 0) ? 0 : (k == 1) ? 13 : 31;
            lv = m[0];
            pl = m[1];
            wr(A_SRC + 8'h8, ALL); wr(A_LVL + 8'h8, ALL); wr(A_POL + 8'h8, ALL);
            pins = '0;
            pins[p] = ~pl;
            repeat (4) @(posedge clk);
            if (lv) wr(A_LVL + 8'h4, 32'h1 << p);
            if (pl) wr(A_POL + 8'h4, 32'h1 << p);
            wr(A_SRC + 8'h4, 32'h1 << p);
            repeat (4) @(posedge clk);
            wr(A_STAT + 8'h8, ALL);
            rd(A_STAT, d);
            chk("R6 inactive pin sets nothing", d, 32'h0);
            @(negedge clk) pins[p] = pl;
            repeat (4) @(posedge clk);
            rd(A_STAT, d);
            chk("R6 active condition sets status", d, 32'h1 << p);
            wr(A_STAT + 8'h8, ALL);
            rd(A_STAT, d);
            chk(lv ? "R9 level re-sets after clear" : "R8 edge status cleared",
                d, lv ? (32'h1 << p) : 32'h0);
            @(negedge clk) pins[p] = ~pl;
            repeat (4) @(posedge clk);
            rd(A_STAT, d);
            chk(lv ? "R8 level status stays sticky" : "R6 opposite edge ignored",
                d, lv ? (32'h1 << p) : 32'h0);
            wr(A_STAT + 8'h8, ALL);
            rd(A_STAT, d);
            chk("R8 clear after inactive", d, 32'h0);
         end
      end

      // R7 source select off: rising edge on pin 7 does nothing
      wr(A_SRC + 8'h8, ALL); wr(A_LVL + 8'h8, ALL); wr(A_POL, 32'h1 << 7);
      pins = '0;
      repeat (4) @(posedge clk);
      @(negedge clk) pins[7] = 1'b1;
      repeat (4) @(posedge clk);
      rd(A_STAT, d);
      chk("R7 no status without source select", d, 32'h0);

      // R8 sticky against base and OR views
      wr(A_SRC, 32'h1 << 7);
      @(negedge clk) pins[7] = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk) pins[7] = 1'b1;
      repeat (10) @(posedge clk);
      wr(A_STAT, 32'h0);
      wr(A_STAT + 8'h4, ALL);
      rd(A_STAT, d);
      chk("R8 status ignores put and or views", d, 32'h1 << 7);

      // R10 interrupt reduction
      @(negedge clk);
      chk("R10 irq low without enable", {31'h0, irq}, 32'h0);
      wr(A_IEN, 32'h1 << 8);
      @(negedge clk);
      chk("R10 irq low on other enable", {31'h0, irq}, 32'h0);
      wr(A_IEN + 8'h4, 32'h1 << 7);
      @(negedge clk);
      chk("R10 irq high", {31'h0, irq}, 32'h1);
      wr(A_IEN + 8'h8, 32'h1 << 7);
      @(negedge clk);
      chk("R10 irq low after disable", {31'h0, irq}, 32'h0);
      wr(A_IEN + 8'h4, 32'h1 << 7);
      wr(A_STAT + 8'h8, 32'h1 << 7);
      @(negedge clk);
      chk("R10 irq low after status clear", {31'h0, irq}, 32'h0);

      // R11 latency, rising edge on pin 20
      wr(A_SRC, 32'h1 << 20); wr(A_POL, 32'h1 << 20); wr(A_LVL, 32'h0);
      repeat (4) @(posedge clk);
      wr(A_STAT + 8'h8, ALL);
      @(negedge clk) pins[20] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      rd(A_STAT, d);
      chk("R11 not yet set after second edge", d, 32'h0);
      rd(A_STAT, d);
      chk("R11 set after third edge", d, 32'h1 << 20);
      chk("R10 irq follows latency", {31'h0, irq}, 32'h0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule